// File: doc/BRIEF.md
# GF(2^8) Gauss-Jordan Linear System Solver

This block solves a square system of linear equations `A·x = b` over the byte field GF(2^8). The system size is set by the parameter `N`, which defaults to 12. The user writes the coefficient matrix and the right-hand side one byte at a time through a small load port. A single `start` pulse then launches the solve.

The solve takes `N` clock cycles, one per pivot column. Each cycle does a complete Gauss-Jordan step:

- It picks the pivot row.
- It inverts the pivot.
- It scales the pivot row to a leading one.
- It clears that column from every other row.

When the last step has been written back, the block raises `done` for one cycle. The solution vector appears on `sol`, and `singular` reports whether any column lacked a usable pivot.

Field arithmetic uses the reduction polynomial x^8+x^4+x^3+x+1, so the low byte of that polynomial is 0x1B. Addition is a bytewise XOR. The inverse of zero is taken to be zero.

Top module: `gf_gj_solver`

## Requirements
- R1: While idle, a load (`ld_en`=1) writes `ld_data` to the matrix element in row `ld_row` and column `ld_col`. A column value equal to `N` selects the right-hand-side entry of that row. The following loads are dropped:
  - any load with `ld_row` ≥ N;
  - any load with `ld_col` > N;
  - any load made while `busy`;
  - any load in a cycle where `start` is accepted.
- R2: A `start` pulse is accepted only while idle. `busy` is then high for exactly N consecutive cycles. A `start` pulse that arrives while `busy` has no effect.
- R3: `done` is high for exactly one cycle: the cycle right after `busy` falls.
- R4: For a nonsingular system, when `done` rises, byte i of `sol` (bits 8i+7 down to 8i) equals x_i, where x is the unique solution of A·x = b over GF(2^8) with reduction polynomial 0x11B.
- R5: When the diagonal entry of the current column is zero, the lowest-indexed row below it that has a nonzero entry in that column is swapped into the pivot position within the same cycle. The solve still returns the correct solution.
- R6: `singular` is 1 together with `done` when some column has no nonzero pivot candidate, including when that happens in the last column. It is 0 for nonsingular systems and is cleared when a start is accepted.
- R7: While idle, `sol` shows the current right-hand-side column of the stored matrix. `sol` and `singular` hold their values until the next accepted start or right-hand-side load.
- R8: After reset, `busy`, `done` and `singular` are 0, and the stored matrix is all zero, so `sol` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Write one matrix byte this cycle |
| ld_row | input | $clog2(N+1) | Row index of the write |
| ld_col | input | $clog2(N+1) | Column index of the write; value N selects the right-hand side |
| ld_data | input | 8 | Byte to write |
| start | input | 1 | Begin a solve (accepted only while idle) |
| busy | output | 1 | Elimination in progress |
| done | output | 1 | One-cycle pulse after the final iteration |
| singular | output | 1 | A column had no nonzero pivot candidate |
| sol | output | 8*N | Solution bytes; byte i holds x_i |

## Verification
Two events can land in the same cycle:

- **Row swap and elimination.** The row swap and the pivot inversion and elimination that use the swapped row happen together. This is provoked with permuted identity matrices, with randomly row-permuted products of triangular factors, and by sweeping every nonzero pivot value. Each case is judged by whether the returned vector matches the one the bench used to build the right-hand side.
- **Pivot failure and completion.** A pivot failure in the last column coincides with the final iteration and with the rise of `done`. This is provoked by a diagonal matrix whose last entry is zero, and judged by `singular` being high in the `done` cycle. A following nonsingular solve must show it cleared.

// File: rtl/gf_gj_pkg.sv
package gf_gj_pkg;

  // low byte of the reduction polynomial x^8+x^4+x^3+x+1
  localparam logic [7:0] GF_POLY_LO = 8'h1B;

  // shift-and-add product, reducing after each doubling
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = {t[6:0], 1'b0} ^ (t[7] ? GF_POLY_LO : 8'h00);
    end
    return acc;
  endfunction

  // a^254 = a^-1 for a != 0, and 0 for a == 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] s;
    r = 8'h01;
    s = a;
    for (int i = 1; i < 8; i++) begin
      s = gf_mul(s, s);
      r = gf_mul(r, s);
    end
    return r;
  endfunction

endpackage

// File: rtl/gf_pivot_select.sv
module gf_pivot_select #(
  parameter int N  = 12,
  parameter int KW = $clog2(N + 1)
) (
  input  logic [N-1:0][7:0] col,
  input  logic [KW-1:0]     k,
  output logic [KW-1:0]     sel,
  output logic              found
);

  // lowest row index at or below k holding a nonzero byte
  always_comb begin
    found = 1'b0;
    sel   = k;
    for (int i = N - 1; i >= 0; i--) begin
      if (i >= int'(k) && col[i] != 8'h00) begin
        found = 1'b1;
        sel   = KW'(i);
      end
    end
  end

endmodule

// File: rtl/gf_gj_iter.sv
module gf_gj_iter
  import gf_gj_pkg::*;
#(
  parameter int N  = 12,
  parameter int KW = $clog2(N + 1)
) (
  input  logic [N-1:0][N:0][7:0] m,
  input  logic [KW-1:0]          k,
  output logic [N-1:0][N:0][7:0] nxt,
  output logic                   found,
  output logic                   swapped,
  output logic [7:0]             pivot
);

  logic [N-1:0][7:0]      colk;
  logic [KW-1:0]          sel;
  logic [N-1:0][N:0][7:0] sw;
  logic [N:0][7:0]        prow;
  logic [7:0]             pinv;
  logic [N-1:0][7:0]      scale;
  logic [N-1:0]           keep;

  for (genvar gi = 0; gi < N; gi++) begin : g_col
    assign colk[gi] = m[gi][k];
  end

  gf_pivot_select #(.N(N), .KW(KW)) u_psel (
    .col   (colk),
    .k     (k),
    .sel   (sel),
    .found (found)
  );

  assign swapped = (sel != k);

  // row exchange of k and sel, before inversion
  for (genvar gi = 0; gi < N; gi++) begin : g_swap
    always_comb begin
      if (KW'(gi) == k)        sw[gi] = m[sel];
      else if (KW'(gi) == sel) sw[gi] = m[k];
      else                     sw[gi] = m[gi];
    end
  end

  assign prow  = sw[k];
  assign pivot = prow[k];
  assign pinv  = gf_inv(pivot);

  // per-row factor: pinv for the pivot row, a_ik * pinv elsewhere
  for (genvar gi = 0; gi < N; gi++) begin : g_rowf
    assign keep[gi]  = (KW'(gi) != k);
    assign scale[gi] = keep[gi] ? gf_mul(sw[gi][k], pinv) : pinv;
  end

  // fused normalize / eliminate cell: one multiply per entry
  for (genvar gi = 0; gi < N; gi++) begin : g_cell_r
    for (genvar gj = 0; gj <= N; gj++) begin : g_cell_c
      assign nxt[gi][gj] = (keep[gi] ? sw[gi][gj] : 8'h00) ^ gf_mul(scale[gi], prow[gj]);
    end
  end

endmodule

// File: rtl/gf_gj_solver.sv
module gf_gj_solver #(
  parameter int N = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [$clog2(N+1)-1:0]        ld_row,
  input  logic [$clog2(N+1)-1:0]        ld_col,
  input  logic [7:0]                    ld_data,
  input  logic                          start,
  output logic                          busy,
  output logic                          done,
  output logic                          singular,
  output logic [8*N-1:0]                sol
);

  localparam int          KW    = $clog2(N + 1);
  localparam logic [KW-1:0] KLAST = KW'(N - 1);

  logic [N-1:0][N:0][7:0] mat;
  logic [N-1:0][N:0][7:0] nxt_m;
  logic [KW-1:0]          k_q;

  // named internal events
  logic       start_ok;
  logic       load_ok;
  logic       iter_fire;
  logic       piv_found;
  logic       piv_swap;
  logic [7:0] piv_val;
  logic [7:0] piv_diag;
  logic [7:0] piv_norm;
  logic       last_iter;

  assign start_ok  = start && !busy;
  assign load_ok   = ld_en && !busy && !start && (ld_row < KW'(N)) && (ld_col <= KW'(N));
  assign iter_fire = busy;
  assign last_iter = busy && (k_q == KLAST);
  assign piv_diag  = mat[k_q][k_q];
  assign piv_norm  = nxt_m[k_q][k_q];

  gf_gj_iter #(.N(N), .KW(KW)) u_iter (
    .m       (mat),
    .k       (k_q),
    .nxt     (nxt_m),
    .found   (piv_found),
    .swapped (piv_swap),
    .pivot   (piv_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mat      <= '0;
      k_q      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      singular <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        busy     <= 1'b1;
        k_q      <= '0;
        singular <= 1'b0;
      end else if (iter_fire) begin
        mat <= nxt_m;
        if (!piv_found) singular <= 1'b1;
        if (last_iter) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          k_q <= k_q + KW'(1);
        end
      end else if (load_ok) begin
        mat[ld_row][ld_col] <= ld_data;
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_sol
    assign sol[8*gi +: 8] = mat[gi][N];
  end

endmodule

// File: rtl/gf_gj_checker.sv
module gf_gj_checker #(
  parameter int N = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           ld_en,
  input logic           busy,
  input logic           done,
  input logic           singular,
  input logic [8*N-1:0] sol,
  input logic           iter_fire,
  input logic           piv_found,
  input logic           piv_swap,
  input logic [7:0]     piv_diag,
  input logic [7:0]     piv_norm
);

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_cnt <= '0;
    else if (start && !busy)  run_cnt <= '0;
    else if (busy)            run_cnt <= run_cnt + 16'd1;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_cnt == 16'(N));

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt < 16'(N - 1)) |=> busy);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_pivot_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_fire && piv_found) |-> piv_norm == 8'h01);

  p_swap_zero_diag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_fire && piv_swap) |-> piv_diag == 8'h00);

  p_singular_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !singular);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !ld_en) |=> ($stable(sol) && $stable(singular)));

endmodule

bind gf_gj_solver gf_gj_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ld_en     (ld_en),
  .busy      (busy),
  .done      (done),
  .singular  (singular),
  .sol       (sol),
  .iter_fire (iter_fire),
  .piv_found (piv_found),
  .piv_swap  (piv_swap),
  .piv_diag  (piv_diag),
  .piv_norm  (piv_norm)
);

// File: tb/gf_gj_solver_tb.sv
module gf_gj_solver_tb;

  localparam int N  = 4;
  localparam int KW = $clog2(N + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ld_en = 1'b0;
  logic [KW-1:0]  ld_row = '0;
  logic [KW-1:0]  ld_col = '0;
  logic [7:0]     ld_data = '0;
  logic           start = 1'b0;
  logic           busy;
  logic           done;
  logic           singular;
  logic [8*N-1:0] sol;

  int checks = 0;
  int fails  = 0;

  logic [7:0] A  [N][N];
  logic [7:0] L  [N][N];
  logic [7:0] U  [N][N];
  logic [7:0] xv [N];
  logic [7:0] bv [N];

  always #4 clk = ~clk;

  gf_gj_solver #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col),
    .ld_data(ld_data), .start(start), .busy(busy), .done(done),
    .singular(singular), .sol(sol)
  );

  // carry-less product, then long division by 0x11B
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'h0000;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int bt = 14; bt >= 8; bt--) if (p[bt]) p = p ^ (16'h011B << (bt - 8));
    return p[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input int c, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_row = KW'(r); ld_col = KW'(c); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic make_b();
    for (int i = 0; i < N; i++) begin
      logic [7:0] s;
      s = 8'h00;
      for (int j = 0; j < N; j++) s = s ^ bmul(A[i][j], xv[j]);
      bv[i] = s;
    end
  endtask

  task automatic load_sys();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) wr(i, j, A[i][j]);
      wr(i, N, bv[i]);
    end
  endtask

  task automatic set_ident();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) A[i][j] = (i == j) ? 8'h01 : 8'h00;
  endtask

  // returns number of busy cycles; poke drives start and a load mid-solve
  task automatic run_solve(input bit poke, output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 50) begin
      if (busy) cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; ld_en = 1'b1; ld_row = '0; ld_col = KW'(N); ld_data = 8'hAA;
      end else begin
        start = 1'b0; ld_en = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; ld_en = 1'b0;
  endtask

  task automatic check_sol(input string req);
    for (int i = 0; i < N; i++) chk(sol[8*i +: 8] == xv[i], req, 64'(sol[8*i +: 8]), 64'(xv[i]));
  endtask

  task automatic gen_rand();
    int perm [N];
    for (int i = 0; i < N; i++) begin
      perm[i] = i;
      for (int j = 0; j < N; j++) begin
        L[i][j] = (j < i) ? 8'($urandom) : ((i == j) ? 8'h01 : 8'h00);
        U[i][j] = (j > i) ? 8'($urandom) : ((i == j) ? 8'($urandom_range(255, 1)) : 8'h00);
      end
    end
    for (int i = N - 1; i > 0; i--) begin
      int j, t;
      j = $urandom_range(i, 0);
      t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic [7:0] s;
        s = 8'h00;
        for (int t = 0; t < N; t++) s = s ^ bmul(L[perm[i]][t], U[t][j]);
        A[i][j] = s;
      end
    for (int i = 0; i < N; i++) xv[i] = 8'($urandom);
    make_b();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [8*N-1:0] hold_sol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    chk(busy == 1'b0, "R8 busy", 64'(busy), 0);
    chk(done == 1'b0, "R8 done", 64'(done), 0);
    chk(singular == 1'b0, "R8 singular", 64'(singular), 0);
    chk(sol == '0, "R8 sol", 64'(sol), 0);

    // R1 / R7: rhs column visible on sol while idle
    wr(2, N, 8'h5C);
    chk(sol[16 +: 8] == 8'h5C, "R1 rhs load", 64'(sol[16 +: 8]), 64'h5C);

    // R4, R2, R3: identity
    set_ident();
    for (int i = 0; i < N; i++) xv[i] = 8'(i + 1);
    make_b();
    load_sys();
    run_solve(1'b0, cyc);
    chk(cyc == N, "R2 busy length", 64'(cyc), 64'(N));
    chk(singular == 1'b0, "R6 identity singular", 64'(singular), 0);
    check_sol("R4 identity");
    @(negedge clk);
    chk(done == 1'b0, "R3 done single pulse", 64'(done), 0);

    // R1: out-of-range writes dropped
    wr(N, 0, 8'hFF);
    wr(0, N + 1, 8'hEE);
    wr(N + 1, N, 8'hDD);
    check_sol("R1 out-of-range rhs");
    run_solve(1'b0, cyc);
    check_sol("R1 out-of-range matrix");

    // R2 / R1: start and load during busy ignored
    run_solve(1'b1, cyc);
    chk(cyc == N, "R2 start while busy", 64'(cyc), 64'(N));
    check_sol("R1 load while busy");

    // R5: reversed identity needs swaps
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) A[i][j] = (j == N - 1 - i) ? 8'h01 : 8'h00;
    for (int i = 0; i < N; i++) xv[i] = 8'(8'h30 + i);
    make_b();
    load_sys();
    run_solve(1'b0, cyc);
    chk(singular == 1'b0, "R5 swap singular", 64'(singular), 0);
    check_sol("R5 reversed identity");

    // R4: sweep every nonzero pivot value
    for (int p = 1; p < 256; p++) begin
      set_ident();
      A[0][0] = 8'(p);
      A[0][1] = 8'h07;
      A[2][0] = 8'(p ^ 8'h5A);
      for (int i = 0; i < N; i++) xv[i] = 8'($urandom);
      make_b();
      load_sys();
      run_solve(1'b0, cyc);
      check_sol("R4 pivot sweep");
    end

    // R4 / R5: random invertible, row-permuted systems
    for (int t = 0; t < 150; t++) begin
      gen_rand();
      load_sys();
      run_solve(1'b0, cyc);
      chk(singular == 1'b0, "R6 random nonsingular", 64'(singular), 0);
      check_sol("R5 random permuted");
    end

    // R6: dependent row
    gen_rand();
    for (int j = 0; j < N; j++) A[3][j] = A[1][j] ^ A[2][j];
    make_b();
    load_sys();
    run_solve(1'b0, cyc);
    chk(singular == 1'b1, "R6 dependent row", 64'(singular), 1);

    // R7: idle hold after done
    hold_sol = sol;
    repeat (10) @(negedge clk);
    chk(sol == hold_sol, "R7 sol hold", 64'(sol), 64'(hold_sol));
    chk(singular == 1'b1, "R7 singular hold", 64'(singular), 1);

    // R6: clears on next nonsingular solve
    set_ident();
    for (int i = 0; i < N; i++) xv[i] = 8'(8'hC0 ^ i);
    make_b();
    load_sys();
    run_solve(1'b0, cyc);
    chk(singular == 1'b0, "R6 cleared", 64'(singular), 0);
    check_sol("R4 after singular");

    // R6: failure in last column, same cycle as completion
    set_ident();
    A[N-1][N-1] = 8'h00;
    for (int i = 0; i < N; i++) xv[i] = 8'h01;
    make_b();
    load_sys();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 50) begin cyc++; @(negedge clk); end
    chk(done == 1'b1 && singular == 1'b1, "R6 last column", 64'({done, singular}), 64'h3);

    // R6: all-zero matrix
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) A[i][j] = 8'h00;
    for (int i = 0; i < N; i++) bv[i] = 8'h00;
    load_sys();
    run_solve(1'b0, cyc);
    chk(singular == 1'b1, "R6 zero matrix", 64'(singular), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule